// File: doc/BRIEF.md
# Programmable Core Alarm Timer

This block is a 32-bit countdown timer placed next to a processor core. Software programs it through a small register port that does single-cycle writes and combinational reads. Four registers sit behind the port: a control register, a reload value, a live count that can only be read, and a clock-ratio selector. A prescaler turns the bus clock into a decrement enable at one of eight ratios from 1 to 128. The live count moves toward zero once per enable.

When the count steps from one to zero, the block raises an interrupt request for a single clock and presents the programmed vector alongside it. In one-shot mode the count then rests at zero. In periodic mode the reload value is copied back in on that same step, so the period is exactly the reload value in enables. A mask bit silences the request without halting the count. Writing the reload register always starts a fresh countdown, and writing zero there halts the timer.

Top module: `core_alarm_timer`

## Requirements
- R1: Out of reset the live count and reload value are zero, the control register reads 0x0001_0000 (masked, one-shot, vector 0), the ratio register reads 0, and no request is raised.
- R2: Register offsets are 0 control, 1 reload, 2 live count, 3 ratio. In control, bits 7:0 hold the vector, bit 16 the mask and bit 17 the mode (1 periodic). In the ratio register only bits 3:0 are kept. All other bits read as zero.
- R3: The ratio code ignores bit 2, and bits {3,1,0} select the divisor: 000 gives /2, 001 /4, 010 /8, 011 /16, 100 /32, 101 /64, 110 /128 and 111 /1. So 0x0 is /2, 0x3 is /16, 0x8 is /32, 0xA is /128, 0xB is /1, and 0x4 acts like 0x0.
- R4: A reload write copies the written value into the live count at that clock edge and restarts the prescaler. The first decrement follows exactly one full divisor of clocks later.
- R5: While the count is non-zero it decrements once per divisor of clocks, and it holds its value between decrements. A read of offset 2 returns the live count.
- R6: In one-shot mode the step from 1 to 0 leaves the count at zero, and no further requests follow.
- R7: In periodic mode the step that would go from 1 to 0 loads the reload value instead, and counting continues.
- R8: The request is high for exactly the one clock after the step from 1, and the vector output carries the control vector only in that clock. Otherwise it reads zero.
- R9: With the mask set, no request is raised, but the count keeps stepping and reloading as usual.
- R10: A reload write of zero halts the timer. The count stays at zero and no request is raised.
- R11: Writes to offset 2 are ignored.
- R12: A ratio write restarts the prescaler and leaves the live count unchanged.
- R13: A reload write in the same clock as a final step wins. The new value is loaded and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one clock per write |
| addr | input | 2 | Register offset |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irqPulse | output | 1 | One-clock interrupt request |
| irqVector | output | 8 | Vector that goes with the request, zero otherwise |

## Verification
A wrong prescaler phase or divisor decode shows up in the live count read back through offset 2. The count moves one clock early or late, within one divisor of the last reload or ratio write. A wrong mode, mask or reload value shows up within one clock of the final step, as a missing, extra or mistagged request or as a wrong value after the reload. The bench keeps its own model of the count, prescaler phase and request. It compares all outputs on every clock, so any divergence is caught in the clock in which it first appears.

// File: rtl/alarm_timer_pkg.sv
package alarm_timer_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_INIT = 2'd1,
    ADDR_CUR  = 2'd2,
    ADDR_DIV  = 2'd3
  } regAddr_t;

  // strobes from the register side to the counting side
  typedef struct packed {
    logic loadInit;
    logic restartPre;
  } strobe_t;

  localparam int EXP_W = 3;

  // ratio code -> log2 of divisor; bit 2 of the code is ignored
  function automatic logic [EXP_W-1:0] divExpOf(input logic [3:0] code);
    return {code[3], code[1], code[0]} + 3'd1;
  endfunction

endpackage

// File: rtl/alarm_timer_regs.sv
module alarm_timer_regs
  import alarm_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [CNT_W-1:0] curCount,
  output strobe_t          strobe,
  output logic [CNT_W-1:0] reloadValue,
  output logic [VEC_W-1:0] vector,
  output logic             maskBit,
  output logic             periodic,
  output logic [EXP_W-1:0] divExp,
  output logic [CNT_W-1:0] rdData
);

  localparam int MASK_POS = 16;
  localparam int MODE_POS = 17;
  localparam int DIV_W    = 4;

  regAddr_t           regSel;
  logic [DIV_W-1:0]   divCode;

  assign regSel = regAddr_t'(addr);

  always_comb begin
    strobe.loadInit   = wrEn && (regSel == ADDR_INIT);
    strobe.restartPre = wrEn && ((regSel == ADDR_INIT) || (regSel == ADDR_DIV));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vector      <= '0;
      maskBit     <= 1'b1;
      periodic    <= 1'b0;
      divCode     <= '0;
      reloadValue <= '0;
    end else if (wrEn) begin
      unique case (regSel)
        ADDR_CTRL: begin
          vector   <= wrData[VEC_W-1:0];
          maskBit  <= wrData[MASK_POS];
          periodic <= wrData[MODE_POS];
        end
        ADDR_INIT: reloadValue <= wrData;
        ADDR_DIV:  divCode     <= wrData[DIV_W-1:0];
        default:   ;
      endcase
    end
  end

  assign divExp = divExpOf(divCode);

  always_comb begin
    rdData = '0;
    unique case (regSel)
      ADDR_CTRL: begin
        rdData[VEC_W-1:0] = vector;
        rdData[MASK_POS]  = maskBit;
        rdData[MODE_POS]  = periodic;
      end
      ADDR_INIT: rdData = reloadValue;
      ADDR_CUR:  rdData = curCount;
      default:   rdData[DIV_W-1:0] = divCode;
    endcase
  end

  // R11
  cur_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == ADDR_CUR) |=> ($stable(reloadValue) && $stable(vector) && $stable(divCode)));

endmodule

// File: rtl/alarm_timer_core.sv
module alarm_timer_core
  import alarm_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [CNT_W-1:0] loadValue,
  input  logic [CNT_W-1:0] reloadValue,
  input  logic [VEC_W-1:0] vector,
  input  logic             maskBit,
  input  logic             periodic,
  input  logic [EXP_W-1:0] divExp,
  output logic [CNT_W-1:0] curCount,
  output logic             irqPulse,
  output logic [VEC_W-1:0] irqVector
);

  localparam int PRE_W = (1 << EXP_W) - 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLast;
  logic             tick;
  logic             lastStep;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) preLast[i] = (i < int'(divExp));
  end

  assign tick     = (preCnt == preLast) && !strobe.restartPre;
  assign lastStep = tick && (curCount == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               preCnt <= '0;
    else if (strobe.restartPre || tick)      preCnt <= '0;
    else                                     preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCount  <= '0;
      irqPulse  <= 1'b0;
      irqVector <= '0;
    end else begin
      irqPulse  <= 1'b0;
      irqVector <= '0;
      if (strobe.loadInit) begin
        curCount <= loadValue;
      end else if (lastStep) begin
        curCount  <= periodic ? reloadValue : '0;
        irqPulse  <= !maskBit;
        irqVector <= maskBit ? '0 : vector;
      end else if (tick && curCount != '0) begin
        curCount <= curCount - 1'b1;
      end
    end
  end

  // R8
  irq_after_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> ($past(curCount) == CNT_W'(1)));
  // R9
  irq_unmasked_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> !$past(maskBit));
  // R4
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadInit |=> (curCount == $past(loadValue)));
  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curCount == '0 && !strobe.loadInit) |=> (curCount == '0 && !irqPulse));
  // R5
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadInit && !tick) |=> $stable(curCount));

endmodule

// File: rtl/core_alarm_timer.sv
module core_alarm_timer
  import alarm_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  output logic             irqPulse,
  output logic [VEC_W-1:0] irqVector
);

  strobe_t          strobe;
  logic [CNT_W-1:0] reloadValue;
  logic [CNT_W-1:0] curCount;
  logic [VEC_W-1:0] vector;
  logic             maskBit;
  logic             periodic;
  logic [EXP_W-1:0] divExp;

  alarm_timer_regs #(.CNT_W(CNT_W), .VEC_W(VEC_W)) regsI (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .curCount(curCount), .strobe(strobe), .reloadValue(reloadValue),
    .vector(vector), .maskBit(maskBit), .periodic(periodic),
    .divExp(divExp), .rdData(rdData)
  );

  alarm_timer_core #(.CNT_W(CNT_W), .VEC_W(VEC_W)) coreI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadValue(wrData),
    .reloadValue(reloadValue), .vector(vector), .maskBit(maskBit),
    .periodic(periodic), .divExp(divExp), .curCount(curCount),
    .irqPulse(irqPulse), .irqVector(irqVector)
  );

endmodule

// File: tb/core_alarm_timer_test.sv
module core_alarm_timer_test;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd2;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqPulse;
  logic [7:0]  irqVector;

  core_alarm_timer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irqPulse(irqPulse), .irqVector(irqVector)
  );

  always #(PERIOD/2) clk = ~clk;

  // behavioural model state
  logic [31:0] mCur, mInit;
  logic [7:0]  mVec, mIrqVec;
  logic        mMask, mPer, mIrq;
  logic [3:0]  mDiv;
  int          mPre;
  int          applied = 0;
  int          bad = 0;
  string       curReq = "R1";
  bit          done = 0;

  function automatic int divisorOf(input logic [3:0] c);
    int e;
    e = ({c[3], c[1], c[0]} + 1) % 8;
    return 1 << e;
  endfunction

  function automatic logic [31:0] expectRead(input logic [1:0] a);
    case (a)
      2'd0: return {14'd0, mPer, mMask, 8'd0, mVec};
      2'd1: return mInit;
      2'd2: return mCur;
      default: return {28'd0, mDiv};
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCur = 0; mInit = 0; mVec = 0; mIrqVec = 0; mMask = 1; mPer = 0;
      mIrq = 0; mDiv = 0; mPre = 0;
    end else begin
      logic fire;
      fire = 0;
      if (wrEn && addr == 2'd1) begin
        mCur = wrData; mPre = 0;
      end else if (wrEn && addr == 2'd3) begin
        mPre = 0;
      end else if (mPre == divisorOf(mDiv) - 1) begin
        mPre = 0;
        if (mCur == 1) begin
          fire = !mMask;
          mCur = mPer ? mInit : 0;
        end else if (mCur != 0) begin
          mCur = mCur - 1;
        end
      end else begin
        mPre = mPre + 1;
      end
      mIrq = fire;
      mIrqVec = fire ? mVec : 8'd0;
      if (wrEn) begin
        case (addr)
          2'd0: begin mVec = wrData[7:0]; mMask = wrData[16]; mPer = wrData[17]; end
          2'd1: mInit = wrData;
          2'd3: mDiv = wrData[3:0];
          default: ;
        endcase
      end
    end
  end

  always begin
    @(posedge clk);
    #(PERIOD/4);
    if (rstN && !done) begin
      applied++;
      if (rdData !== expectRead(addr)) begin
        bad++;
        $display("FAIL %s: rdData[addr %0d] = %h, expected %h", curReq, addr, rdData, expectRead(addr));
      end
      if (irqPulse !== mIrq || irqVector !== mIrqVec) begin
        bad++;
        $display("FAIL %s: irq/vector = %b/%h, expected %b/%h", curReq, irqPulse, irqVector, mIrq, mIrqVec);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addr = 2'd2;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] a);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    addr = 2'd2;
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    curReq = "R1";
    for (int a = 0; a < 4; a++) peek(2'(a));

    curReq = "R2";
    wr(2'd0, 32'hFFFC_FF5A);       // vector 5A, unmasked, one-shot, stray bits
    wr(2'd3, 32'hFFFF_FFFB);       // /1 with stray bits
    for (int a = 0; a < 4; a++) peek(2'(a));

    curReq = "R6";
    wr(2'd1, 32'd5);
    idle(10);

    curReq = "R3";
    wr(2'd3, 32'h0); wr(2'd1, 32'd3); idle(10);
    wr(2'd3, 32'h4); wr(2'd1, 32'd3); idle(10);
    wr(2'd3, 32'h1); wr(2'd1, 32'd2); idle(12);
    wr(2'd3, 32'h3); wr(2'd1, 32'd2); idle(40);
    wr(2'd3, 32'h8); wr(2'd1, 32'd2); idle(70);
    wr(2'd3, 32'h9); wr(2'd1, 32'd2); idle(135);
    wr(2'd3, 32'hA); wr(2'd1, 32'd2); idle(260);
    wr(2'd3, 32'h2); wr(2'd1, 32'd2); idle(20);

    curReq = "R4";
    wr(2'd3, 32'h2); wr(2'd1, 32'd9); idle(3); wr(2'd1, 32'd4); idle(40);

    curReq = "R5";
    wr(2'd3, 32'hB); wr(2'd1, 32'd6); idle(4); peek(2'd1); idle(4);

    curReq = "R7";
    wr(2'd0, 32'h0002_0033); wr(2'd1, 32'd4); idle(20);
    wr(2'd3, 32'h0); idle(20);

    curReq = "R8";
    wr(2'd3, 32'hB); wr(2'd0, 32'h0002_00C7); wr(2'd1, 32'd1); idle(6);

    curReq = "R9";
    wr(2'd0, 32'h0003_0011); wr(2'd1, 32'd3); idle(12);
    wr(2'd0, 32'h0002_0011); idle(10);

    curReq = "R12";
    wr(2'd3, 32'h1); wr(2'd1, 32'd8); idle(6); wr(2'd3, 32'h1); idle(6);
    wr(2'd3, 32'hB); idle(10);

    curReq = "R13";
    wr(2'd0, 32'h0000_0044); wr(2'd1, 32'd3); idle(1); wr(2'd1, 32'd7); idle(10);

    curReq = "R11";
    wr(2'd1, 32'd20); wr(2'd2, 32'd2); idle(3); peek(2'd1); idle(2);

    curReq = "R10";
    wr(2'd0, 32'h0002_0022); wr(2'd1, 32'd0); idle(20); peek(2'd1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

endmodule